// File: doc/BRIEF.md
# Three-Bus Register Datapath with Step Sequencer

This block is a minimal processor datapath organised around three buses. A register file with two read ports and one write port puts two operands on source buses A and B at once, the ALU combines them, and the result returns on bus C to the write port in the same clock. A hardwired four-step counter produces every control signal. It fetches an instruction through a simple read port, waits for the memory to report completion, loads the instruction register and then executes a register-to-register add in one step.

During fetch the program counter goes through the ALU unchanged (pass-B) into the address register. A separate incrementer advances the program counter by 4 in that same step. Instruction words are 32 bits:

| Bits | Field |
|------|-------|
| [31:24] | opcode |
| [23:20] | first source |
| [19:16] | second source |
| [15:12] | destination |

The remaining bits are ignored. Opcode 0x01 is the add. Every other opcode retires without writing anything. The write port and the end-of-instruction strobe are brought out so that the integrating logic can observe retirement.

Top module: `tribus_core`

## Requirements
- R1: Reset behaviour:
  - While reset is low, `mem_req_valid`, `instr_done` and `wb_en` are 0.
  - After reset the program counter is 0 and each register Ri holds the value i.
- R2: Instruction fetch requests carry byte addresses 0, 4, 8, … in strict order, one per instruction.
- R3: A raised read request keeps `mem_req_valid` high and `mem_addr` unchanged until a cycle with `mem_req_ready` high accepts it.
- R4: Read data is captured only on an `mem_mfc` pulse that comes after the request was accepted and while the sequencer is waiting. Pulses at any other time have no effect on the instruction executed.
- R5: Opcode 0x01 in bits [31:24] writes srcA + srcB, modulo 2^32, to the destination register:
  - srcA is the register named in bits [23:20].
  - srcB is the register named in bits [19:16].
  - The destination is the register named in bits [15:12].
  - The write happens in the cycle that `instr_done` is high and shows on `wb_en`, `wb_sel` and `wb_data`.
- R6: Both reads and the write occur in the same clock. A destination equal to a source therefore reads that source's old value.
- R7: Any opcode other than 0x01 asserts `instr_done` after the fetch steps with `wb_en` low. `wb_en` is never high without `instr_done`.
- R8: Execution timing:
  - `instr_done` is a single-cycle pulse exactly two cycles after the cycle of the accepted `mem_mfc` pulse.
  - No read request is raised while `instr_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | 32 | Byte address of the read (address register) |
| mem_mfc | input | 1 | One-cycle memory-function-complete pulse with data |
| mem_rd_data | input | 32 | Read data, valid with `mem_mfc` |
| wb_en | output | 1 | Register write on bus C this cycle |
| wb_sel | output | 4 | Destination register index |
| wb_data | output | 32 | Bus C value being written |
| instr_done | output | 1 | End step: instruction retires this cycle |

## Verification
The hardest situation to reach from the ports is a completion pulse that must be ignored. Such pulses arrive while the request is still unaccepted, or during the load and execute steps, and each would corrupt the next instruction if it were honoured. The bench memory model randomly injects stray `mem_mfc` pulses that carry junk data in exactly those windows. It also randomises ready and completion latency, so retirement results show whether a stray was latched. A directed run doubles register 15 forty times to force the add past 2^32, and other directed instructions cover reads of the register being written.

// File: rtl/tribus_pkg.sv
// Package: shared types for the three-bus datapath.
// Holds the step encoding, ALU operations, bus-B source select and the
// control word that the sequencer hands to the datapath.
package tribus_pkg;

    localparam int OPC_W = 8;
    localparam logic [OPC_W-1:0] OPC_ADD = 8'h01;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_WAIT   = 2'd1,
        ST_LOADIR = 2'd2,
        ST_EXEC   = 2'd3
    } step_e;

    typedef enum logic {
        ALU_PASSB = 1'b0,
        ALU_ADD   = 1'b1
    } alu_op_e;

    typedef enum logic [1:0] {
        BSRC_PC  = 2'd0,
        BSRC_MDR = 2'd1,
        BSRC_RF  = 2'd2
    } bsrc_e;

    typedef struct packed {
        bsrc_e   bsrc;
        alu_op_e alu_op;
        logic    sel_a;
        logic    mar_in;
        logic    ir_in;
        logic    mdr_in;
        logic    rf_in;
        logic    inc_pc;
        logic    end_step;
    } ctrl_t;

endpackage

// File: rtl/tribus_regfile.sv
// Module: register file with two read ports and one write port.
// Assumes: reads are combinational, the write lands at the clock edge, so a
// same-cycle read of the written register returns the old value.
// Reset loads each register with its own index.
module tribus_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_a_sel,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        // Holds one register; reset to its index, updated from bus C.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[gi] <= DATA_W'(gi);
            end else if (wr_en && (wr_sel == SEL_W'(gi))) begin
                regs[gi] <= wr_data;
            end
        end
    end

    // Two independent read ports onto buses A and B.
    always_comb begin
        rd_a_data = regs[rd_a_sel];
        rd_b_data = regs[rd_b_sel];
    end

endmodule

// File: rtl/tribus_alu.sv
// Module: ALU with pass-B and add.
// Assumes: sel_a gates bus A into the adder; when low the A operand is zero,
// so add with sel_a low also yields B.
module tribus_alu
    import tribus_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] bus_a,
    input  logic [DATA_W-1:0] bus_b,
    input  alu_op_e           op,
    input  logic              sel_a,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] a_opnd;

    // Select the A operand and compute the result onto bus C.
    always_comb begin
        a_opnd = sel_a ? bus_a : '0;
        unique case (op)
            ALU_ADD:   result = a_opnd + bus_b;
            default:   result = bus_b;
        endcase
    end

endmodule

// File: rtl/tribus_seq.sv
// Module: hardwired four-step sequencer.
// Steps: fetch (PC->MAR via ALU, increment PC, raise read), wait for
// completion, load IR from MDR, execute with End. Assumes MFC is a single
// pulse arriving after the read request has been accepted.
module tribus_seq
    import tribus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             mem_ready,
    input  logic             mem_mfc,
    output logic             req_valid,
    output ctrl_t            ctrl
);

    step_e step_q;
    logic  pend_q;
    logic  mfc_take;

    // A completion counts only while waiting and after the handshake.
    always_comb mfc_take = (step_q == ST_WAIT) && mem_mfc && !pend_q;

    // Step counter: stalls in WAIT, End returns it to FETCH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_FETCH;
        end else begin
            unique case (step_q)
                ST_FETCH:  step_q <= ST_WAIT;
                ST_WAIT:   step_q <= mfc_take ? ST_LOADIR : ST_WAIT;
                ST_LOADIR: step_q <= ST_EXEC;
                default:   step_q <= ST_FETCH;
            endcase
        end
    end

    // Read request flag: raised in fetch, cleared on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (step_q == ST_FETCH) begin
            pend_q <= 1'b1;
        end else if (pend_q && mem_ready) begin
            pend_q <= 1'b0;
        end
    end

    always_comb req_valid = pend_q;

    // Control word decode from step and opcode.
    always_comb begin
        ctrl        = '0;
        ctrl.bsrc   = BSRC_PC;
        ctrl.alu_op = ALU_PASSB;
        unique case (step_q)
            ST_FETCH: begin
                ctrl.bsrc   = BSRC_PC;
                ctrl.mar_in = 1'b1;
                ctrl.inc_pc = 1'b1;
            end
            ST_WAIT: begin
                ctrl.mdr_in = mfc_take;
            end
            ST_LOADIR: begin
                ctrl.bsrc  = BSRC_MDR;
                ctrl.ir_in = 1'b1;
            end
            default: begin
                ctrl.end_step = 1'b1;
                if (opcode == OPC_ADD) begin
                    ctrl.bsrc   = BSRC_RF;
                    ctrl.alu_op = ALU_ADD;
                    ctrl.sel_a  = 1'b1;
                    ctrl.rf_in  = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/tribus_core.sv
// Module: top of the three-bus datapath.
// Holds PC with its +STEP incrementer, MAR, MDR and IR, the bus-B source mux,
// and wires the register file, ALU and sequencer together. Assumes 32-bit
// words and byte addresses of the same width as data.
module tribus_core
    import tribus_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NREG     = 16,
    parameter int PC_STEP  = 4,
    parameter logic [DATA_W-1:0] RESET_PC = '0,
    localparam int SEL_W   = $clog2(NREG),
    localparam int OPC_LSB = DATA_W - OPC_W,
    localparam int SA_LSB  = OPC_LSB - SEL_W,
    localparam int SB_LSB  = SA_LSB - SEL_W,
    localparam int DST_LSB = SB_LSB - SEL_W,
    localparam int IR_W    = DATA_W - DST_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_mfc,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              wb_en,
    output logic [SEL_W-1:0]  wb_sel,
    output logic [DATA_W-1:0] wb_data,
    output logic              instr_done
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] pc_q, mar_q, mdr_q;
    logic [IR_W-1:0]   ir_q;
    logic [DATA_W-1:0] bus_a, bus_b, bus_c, rf_b;
    logic [OPC_W-1:0]  opcode;
    logic [SEL_W-1:0]  src_a, src_b, dst;

    // Split the held instruction fields.
    always_comb begin
        opcode = ir_q[IR_W-1 -: OPC_W];
        src_a  = ir_q[SA_LSB-DST_LSB +: SEL_W];
        src_b  = ir_q[SB_LSB-DST_LSB +: SEL_W];
        dst    = ir_q[0 +: SEL_W];
    end

    tribus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .mem_ready (mem_req_ready),
        .mem_mfc   (mem_mfc),
        .req_valid (mem_req_valid),
        .ctrl      (ctrl)
    );

    tribus_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_sel  (src_a),
        .rd_b_sel  (src_b),
        .rd_a_data (bus_a),
        .rd_b_data (rf_b),
        .wr_en     (ctrl.rf_in),
        .wr_sel    (dst),
        .wr_data   (bus_c)
    );

    // Bus B source select: PC, MDR or register port B.
    always_comb begin
        unique case (ctrl.bsrc)
            BSRC_PC:  bus_b = pc_q;
            BSRC_MDR: bus_b = mdr_q;
            default:  bus_b = rf_b;
        endcase
    end

    tribus_alu #(.DATA_W(DATA_W)) u_alu (
        .bus_a  (bus_a),
        .bus_b  (bus_b),
        .op     (ctrl.alu_op),
        .sel_a  (ctrl.sel_a),
        .result (bus_c)
    );

    // Program counter with its own incrementer, outside the ALU.
    always_ff @(posedge clk) begin
        if (!rst_n)           pc_q <= RESET_PC;
        else if (ctrl.inc_pc) pc_q <= pc_q + DATA_W'(PC_STEP);
    end

    // Memory address register, loaded from bus C.
    always_ff @(posedge clk) begin
        if (!rst_n)           mar_q <= '0;
        else if (ctrl.mar_in) mar_q <= bus_c;
    end

    // Memory data register, loaded from the memory on accepted completion.
    always_ff @(posedge clk) begin
        if (!rst_n)           mdr_q <= '0;
        else if (ctrl.mdr_in) mdr_q <= mem_rd_data;
    end

    // Instruction register: keeps only the decoded upper fields of bus C.
    always_ff @(posedge clk) begin
        if (!rst_n)          ir_q <= '0;
        else if (ctrl.ir_in) ir_q <= bus_c[DATA_W-1:DST_LSB];
    end

    // Outputs: memory address and the bus-C write port.
    always_comb begin
        mem_addr   = mar_q;
        wb_en      = ctrl.rf_in;
        wb_sel     = dst;
        wb_data    = bus_c;
        instr_done = ctrl.end_step;
    end

endmodule

// File: rtl/tribus_core_chk.sv
// Module: property checker for tribus_core, attached by bind.
// Tracks the last accepted fetch address to check sequential fetch.
module tribus_core_chk #(
    parameter int DATA_W  = 32,
    parameter int PC_STEP = 4,
    parameter logic [DATA_W-1:0] RESET_PC = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [DATA_W-1:0] mem_addr,
    input logic              wb_en,
    input logic              instr_done
);

    logic              seen_q;
    logic [DATA_W-1:0] last_q;
    logic              accept;

    always_comb accept = mem_req_valid && mem_req_ready;

    // Remember the previously accepted fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (accept) begin
            seen_q <= 1'b1;
            last_q <= mem_addr;
        end
    end

    p_first_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !seen_q) |-> (mem_addr == RESET_PC));

    p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && seen_q) |-> (mem_addr == last_q + DATA_W'(PC_STEP)));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

    p_write_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> instr_done);

    p_end_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);

    p_no_req_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> !mem_req_valid);

endmodule

bind tribus_core tribus_core_chk #(
    .DATA_W   (DATA_W),
    .PC_STEP  (PC_STEP),
    .RESET_PC (RESET_PC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .wb_en         (wb_en),
    .instr_done    (instr_done)
);

// File: tb/tribus_core_tb_top.sv
`timescale 1ns/1ps
// Bench: random memory timing with stray completion pulses, a register
// model updated at fetch, and checks at every retirement.
module tribus_core_tb_top;

    localparam int DW     = 32;
    localparam int NR     = 16;
    localparam int NINSTR = 300;
    localparam int LIMIT  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req_ready = 1'b0;
    logic          mem_mfc = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;
    logic          mem_req_valid, wb_en, instr_done;
    logic [DW-1:0] mem_addr, wb_data;
    logic [3:0]    wb_sel;

    always #2 clk = ~clk;

    tribus_core dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_addr      (mem_addr),
        .mem_mfc       (mem_mfc),
        .mem_rd_data   (mem_rd_data),
        .wb_en         (wb_en),
        .wb_sel        (wb_sel),
        .wb_data       (wb_data),
        .instr_done    (instr_done)
    );

    int          checks = 0;
    int          fails  = 0;
    int unsigned cyc    = 0;
    int unsigned mfc_cyc = 0;
    int          n_fetch = 0;
    int          n_done  = 0;
    int          strays  = 0;
    int          strays_seen = 0;
    bit          go = 1'b0;
    logic [DW-1:0] model [NR];
    bit          exp_wr;
    logic [3:0]  exp_idx;
    logic [DW-1:0] exp_data;
    bit          exp_same;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Instruction at fetch number n: directed corners first, then random.
    function automatic logic [DW-1:0] make_instr(input int n);
        logic [7:0] op;
        logic [3:0] a, b, d;
        if (n == 0) begin
            op = 8'h01; a = 4'd1; b = 4'd2; d = 4'd3;
        end else if (n == 1) begin
            op = 8'h7F; a = 4'd3; b = 4'd3; d = 4'd0;
        end else if (n == 2) begin
            op = 8'h01; a = 4'd3; b = 4'd3; d = 4'd3;
        end else if (n < 43) begin
            op = 8'h01; a = 4'd15; b = 4'd15; d = 4'd15;
        end else begin
            op = ($urandom % 5 == 0) ? 8'(8'h02 + ($urandom % 200)) : 8'h01;
            a = 4'($urandom); b = 4'($urandom); d = 4'($urandom);
        end
        return {op, a, b, d, 12'h000};
    endfunction

    // Memory responder: random ready and latency, stray completion pulses.
    initial begin
        bit          hold_prev = 1'b0;
        logic [DW-1:0] hold_addr = '0;
        wait (go);
        forever begin
            @(negedge clk);
            mem_mfc = 1'b0;
            mem_req_ready = 1'b0;
            if (hold_prev)
                chk(mem_req_valid && mem_addr == hold_addr, "R3", "held request address",
                    mem_addr, hold_addr);
            hold_prev = 1'b0;
            if (!mem_req_valid || ($urandom % 3 != 0)) begin
                if (mem_req_valid) begin
                    hold_prev = 1'b1;
                    hold_addr = mem_addr;
                end
                if ($urandom % 6 == 0) begin
                    mem_mfc = 1'b1;
                    mem_rd_data = $urandom;
                    strays++;
                end
            end else begin
                logic [DW-1:0] ins;
                logic [3:0] a, b, d;
                mem_req_ready = 1'b1;
                chk(mem_addr == DW'(4 * n_fetch), (n_fetch == 0) ? "R1" : "R2",
                    "fetch address", mem_addr, DW'(4 * n_fetch));
                ins = make_instr(n_fetch);
                n_fetch++;
                a = ins[23:20]; b = ins[19:16]; d = ins[15:12];
                exp_wr   = (ins[31:24] == 8'h01);
                exp_idx  = d;
                exp_same = (a == d) || (b == d);
                exp_data = model[a] + model[b];
                if (exp_wr) model[d] = exp_data;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int k = 0; k < int'($urandom % 4); k++) @(negedge clk);
                mem_mfc = 1'b1;
                mem_rd_data = ins;
                mfc_cyc = cyc;
            end
        end
    end

    // Retirement monitor: compares bus-C write and timing with the model.
    initial begin
        wait (go);
        forever begin
            @(negedge clk);
            if (wb_en && !instr_done)
                chk(1'b0, "R7", "write without end", 32'(wb_en), 32'd0);
            if (instr_done) begin
                string tag;
                if (!exp_wr)                  tag = "R7";
                else if (strays != strays_seen) tag = "R4";
                else if (exp_same)            tag = "R6";
                else                          tag = "R5";
                strays_seen = strays;
                chk(wb_en == exp_wr, tag, "write enable", 32'(wb_en), 32'(exp_wr));
                if (exp_wr) begin
                    chk(wb_sel == exp_idx, tag, "dest index", 32'(wb_sel), 32'(exp_idx));
                    chk(wb_data == exp_data, tag, "result", wb_data, exp_data);
                end
                chk(cyc - mfc_cyc == 2, "R8", "mfc to end cycles", cyc - mfc_cyc, 32'd2);
                chk(!mem_req_valid, "R8", "request during end", 32'(mem_req_valid), 32'd0);
                n_done++;
            end
        end
    end

    // Main: reset checks, run, summary.
    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) model[i] = DW'(i);
        repeat (3) @(negedge clk);
        chk(!mem_req_valid, "R1", "valid in reset", 32'(mem_req_valid), 32'd0);
        chk(!instr_done, "R1", "done in reset", 32'(instr_done), 32'd0);
        chk(!wb_en, "R1", "write in reset", 32'(wb_en), 32'd0);
        rst_n = 1'b1;
        go = 1'b1;
        while (n_done < NINSTR && cyc < LIMIT) @(posedge clk);
        if (cyc >= LIMIT) chk(1'b0, "R8", "watchdog expired", cyc, LIMIT);
        chk(n_done >= NINSTR, "R2", "instructions retired", n_done, NINSTR);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule